// File: doc/BRIEF.md
# IF-Sampling Quadrature Demodulator

This block takes a digitised intermediate-frequency probe signal and extracts its in-phase (I) and quadrature (Q) components. The sample clock is locked to the IF at exactly eight samples per IF period. Consecutive samples therefore sit 45 degrees apart in IF phase. Each sample is weighted by the cosine and the sine of its phase slot. A sum over the last full IF period gives I and Q. No mixer and no low-pass filter are needed.

A three-bit slot counter tags every sample with its phase. Two small constant tables supply 9-bit signed weights. Two hardware multipliers form the products. A running sum adds the newest product and drops the one that has just left the eight-sample window. Both sums are rounded to 16 bits and registered on the outputs, so a fresh I/Q pair is available on every clock once the window is full. A sync pulse realigns the slot counter with the IF and discards the accumulated history.

Top module: `iq_demod`

## Requirements
- R1: While reset is held, and until results arrive, `i_o`, `q_o` and `valid_o` are 0.
- R2: The first sample after reset takes slot 0. Every later sample takes the next slot, modulo 8. A sample presented with `sync_i` high takes slot 0, and the slots that follow it are 1, 2, and so on.
- R3: The cosine weight for slots 0 to 7 is 255, 180, 0, -180, -255, -180, 0, 180. The sine weight for slot k equals the cosine weight for slot (k+6) mod 8, which gives 0, 180, 255, 180, 0, -180, -255, -180.
- R4: The full-precision I equals the sum of sample × cosine weight over the 8 most recent samples. Q is the same sum with the sine weights. A sample stops contributing once 8 newer samples have arrived.
- R5: The output word equals floor((sum + 512) / 1024), as a 16-bit two's-complement value.
- R6: Suppose a sample is captured at rising edge k. The outputs that include it appear after rising edge k+2.
- R7: `valid_o` is high only when the window holds 8 samples taken since the last reset or sync. Once high, it stays high on every clock until a sync arrives.
- R8: A sync discards all earlier samples. A window never mixes samples from before and after a sync, and `valid_o` falls three edges after the sync is sampled.
- R9: Full-scale inputs (-8192 and 8191) in any pattern give exact results, with no wrap-around.
- R10: Take an IF sinusoid of amplitude A and phase φ, sampled on slot boundaries. The outputs are then I ≈ A·cos φ·1020/1024 and Q ≈ −A·sin φ·1020/1024, within 2 + A/1000 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, eight times the IF |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Marks the presented sample as slot 0 and clears the history |
| sample_i | input | 14 | Signed ADC sample |
| i_o | output | 16 | Rounded in-phase sum |
| q_o | output | 16 | Rounded quadrature sum |
| valid_o | output | 1 | I/Q cover a complete window |

## Verification
The assertions assume that a new sample arrives on every clock after reset. They also assume that `sync_i` is a clean, synchronous level, and that it is low while reset is held. The stimulus respects this. The bench drives a fresh sample at each falling edge and keeps sync at 0 throughout reset. It releases reset on the same edge as the first sample, so no dummy sample enters the window. Random samples cover the full 14-bit range, and random syncs land at arbitrary points, including back to back.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;

   // Weight for one of eight 45-degree slots, cosine order, scaled to the
   // largest positive value of a ww-bit signed word.
   function automatic int octant_weight(input int idx, input int ww);
      int amp;
      int diag;
      amp  = (1 << (ww - 1)) - 1;
      diag = int'((longint'(amp) * 64'sd46341 + 64'sd32768) >>> 16);
      case (idx % 8)
         0:       return amp;
         1:       return diag;
         3:       return -diag;
         4:       return -amp;
         5:       return -diag;
         7:       return diag;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/iq_phase_gen.sv
module iq_phase_gen
   import iq_demod_pkg::*;
#(
   parameter int PHASES   = 8,
   parameter int WEIGHT_W = 9
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       sync_i,
   output logic signed [WEIGHT_W-1:0] cos_o,
   output logic signed [WEIGHT_W-1:0] sin_o
);
   localparam int PH_W   = $clog2(PHASES);
   localparam int STRIDE = 8 / PHASES;

   generate
      if (PHASES != 4 && PHASES != 8) begin : g_bad_phases
         $error("iq_phase_gen: PHASES must be 4 or 8");
      end
      if (WEIGHT_W < 3) begin : g_bad_weight
         $error("iq_phase_gen: WEIGHT_W too small");
      end
   endgenerate

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_cur;
   logic signed [WEIGHT_W-1:0] cos_tab [PHASES];
   logic signed [WEIGHT_W-1:0] sin_tab [PHASES];

   for (genvar k = 0; k < PHASES; k++) begin : g_tab
      assign cos_tab[k] = WEIGHT_W'(octant_weight(k * STRIDE, WEIGHT_W));
      assign sin_tab[k] = WEIGHT_W'(octant_weight((k * STRIDE + 6) % 8, WEIGHT_W));
   end

   assign ph_cur = sync_i ? '0 : ph_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) ph_q <= '0;
      else       ph_q <= ph_cur + PH_W'(1);
   end

   assign cos_o = cos_tab[ph_cur];
   assign sin_o = sin_tab[ph_cur];

   AST_PHASE_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
      sync_i |=> ph_q == PH_W'(1)); // R2
   AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      !sync_i |=> ph_q == PH_W'($past(ph_q) + PH_W'(1))); // R2

endmodule

// File: rtl/iq_mixer.sv
module iq_mixer #(
   parameter int SAMPLE_W = 14,
   parameter int WEIGHT_W = 9,
   localparam int PROD_W  = SAMPLE_W + WEIGHT_W
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       sync_i,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic signed [WEIGHT_W-1:0] cos_i,
   input  logic signed [WEIGHT_W-1:0] sin_i,
   output logic signed [PROD_W-1:0]   prod_i_o,
   output logic signed [PROD_W-1:0]   prod_q_o,
   output logic                       sync_o,
   output logic                       valid_o
);
   logic signed [WEIGHT_W-1:0] w   [2];
   logic signed [PROD_W-1:0]   prd [2];

   assign w[0] = cos_i;
   assign w[1] = sin_i;

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      always_ff @(posedge clk_i) begin
         if (rst_i) prd[ch] <= '0;
         else       prd[ch] <= sample_i * w[ch];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sync_o  <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         sync_o  <= sync_i;
         valid_o <= 1'b1;
      end
   end

   assign prod_i_o = prd[0];
   assign prod_q_o = prd[1];

   AST_ZERO_PRODUCT: assert property (@(posedge clk_i) disable iff (rst_i)
      sample_i == '0 |=> prod_i_o == '0 && prod_q_o == '0); // R4

endmodule

// File: rtl/iq_window_acc.sv
module iq_window_acc #(
   parameter int    PROD_W   = 23,
   parameter int    PHASES   = 8,
   parameter int    ACC_W    = 26,
   parameter longint PROD_MAX = 2088960
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     en_i,
   input  logic                     clear_i,
   input  logic signed [PROD_W-1:0] prod_i,
   output logic signed [ACC_W-1:0]  acc_o,
   output logic                     full_o
);
   localparam int     CNT_W = $clog2(PHASES + 1);
   localparam longint LIMIT = PROD_MAX * PHASES;

   generate
      if (ACC_W < PROD_W + $clog2(PHASES)) begin : g_bad_acc
         $error("iq_window_acc: accumulator too narrow");
      end
   endgenerate

   logic signed [PROD_W-1:0] dly [PHASES];
   logic [CNT_W-1:0]         fill_q;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  base;
   logic signed [ACC_W-1:0]  drop;
   logic                     full;

   assign full = fill_q == CNT_W'(PHASES);

   always_comb begin
      base = clear_i ? '0 : acc_q;
      drop = (full && !clear_i) ? ACC_W'(dly[PHASES-1]) : '0;
   end

   for (genvar k = 0; k < PHASES; k++) begin : g_dly
      if (k == 0) begin : g_head
         always_ff @(posedge clk_i) begin
            if (rst_i)     dly[k] <= '0;
            else if (en_i) dly[k] <= prod_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk_i) begin
            if (rst_i)     dly[k] <= '0;
            else if (en_i) dly[k] <= dly[k-1];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q  <= '0;
         fill_q <= '0;
      end else if (en_i) begin
         acc_q  <= base + ACC_W'(prod_i) - drop;
         fill_q <= clear_i ? CNT_W'(1) : (full ? fill_q : fill_q + CNT_W'(1));
      end
   end

   assign acc_o  = acc_q;
   assign full_o = full;

   AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      fill_q <= CNT_W'(PHASES)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
      longint'(acc_q) <= LIMIT && longint'(acc_q) >= -LIMIT); // R9
   AST_CLEAR_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i && clear_i |=> fill_q == CNT_W'(1)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(acc_q) && $stable(fill_q)); // R4

endmodule

// File: rtl/iq_round.sv
module iq_round #(
   parameter int ACC_W = 26,
   parameter int OUT_W = 16
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [OUT_W-1:0] out_o
);
   localparam int SHIFT = ACC_W - OUT_W;

   generate
      if (SHIFT > 0) begin : g_round
         logic signed [ACC_W:0] biased;
         assign biased = ACC_W'(acc_i) + ((ACC_W + 1)'(1) <<< (SHIFT - 1));
         assign out_o  = OUT_W'(biased >>> SHIFT);
      end else begin : g_extend
         assign out_o = OUT_W'(acc_i);
      end
   endgenerate

endmodule

// File: rtl/iq_demod.sv
module iq_demod #(
   parameter int SAMPLE_W = 14,
   parameter int WEIGHT_W = 9,
   parameter int PHASES   = 8,
   parameter int OUT_W    = 16
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       sync_i,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   output logic signed [OUT_W-1:0]    i_o,
   output logic signed [OUT_W-1:0]    q_o,
   output logic                       valid_o
);
   localparam int     PROD_W   = SAMPLE_W + WEIGHT_W;
   localparam int     ACC_W    = PROD_W + $clog2(PHASES);
   localparam longint PROD_MAX = (longint'(1) << (SAMPLE_W - 1)) *
                                 ((longint'(1) << (WEIGHT_W - 1)) - 1);
   localparam longint PEAK     = PROD_MAX * PHASES;

   generate
      if (SAMPLE_W < 4 || SAMPLE_W > 24) begin : g_bad_sample
         $error("iq_demod: SAMPLE_W out of range");
      end
      if (WEIGHT_W < 3 || WEIGHT_W > 18) begin : g_bad_weight
         $error("iq_demod: WEIGHT_W out of range");
      end
      if (OUT_W < ACC_W && (PEAK >> (ACC_W - OUT_W)) >= (longint'(1) << (OUT_W - 1)))
      begin : g_bad_out
         $error("iq_demod: OUT_W cannot hold a full-scale result");
      end
   endgenerate

   logic signed [WEIGHT_W-1:0] cos_w, sin_w;
   logic signed [PROD_W-1:0]   prod [2];
   logic signed [ACC_W-1:0]    acc  [2];
   logic signed [OUT_W-1:0]    rnd  [2];
   logic                       full [2];
   logic                       p_sync, p_valid;

   iq_phase_gen #(.PHASES(PHASES), .WEIGHT_W(WEIGHT_W)) i_phase (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .sync_i(sync_i),
      .cos_o (cos_w),
      .sin_o (sin_w)
   );

   iq_mixer #(.SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W)) i_mixer (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sync_i  (sync_i),
      .sample_i(sample_i),
      .cos_i   (cos_w),
      .sin_i   (sin_w),
      .prod_i_o(prod[0]),
      .prod_q_o(prod[1]),
      .sync_o  (p_sync),
      .valid_o (p_valid)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      iq_window_acc #(
         .PROD_W  (PROD_W),
         .PHASES  (PHASES),
         .ACC_W   (ACC_W),
         .PROD_MAX(PROD_MAX)
      ) i_acc (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .en_i   (p_valid),
         .clear_i(p_sync),
         .prod_i (prod[ch]),
         .acc_o  (acc[ch]),
         .full_o (full[ch])
      );

      iq_round #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_round (
         .acc_i(acc[ch]),
         .out_o(rnd[ch])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         i_o     <= '0;
         q_o     <= '0;
         valid_o <= 1'b0;
      end else begin
         i_o     <= rnd[0];
         q_o     <= rnd[1];
         valid_o <= full[0];
      end
   end

   AST_CHANNELS_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
      full[0] == full[1]); // R7
   AST_SYNC_DROPS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
      sync_i |-> ##3 !valid_o); // R8
   AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o && !$past(sync_i, 2) |=> valid_o); // R7
   AST_RESET_QUIET: assert property (@(posedge clk_i)
      $past(rst_i) |-> !valid_o && i_o == '0 && q_o == '0); // R1

endmodule

// File: tb/test_iq_demod.sv
module test_iq_demod;
   logic               clk_i = 1'b0;
   logic               rst_i = 1'b1;
   logic               sync_i = 1'b0;
   logic signed [13:0] sample_i = '0;
   logic signed [15:0] i_o, q_o;
   logic               valid_o;

   iq_demod i_iq_demod (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sync_i  (sync_i),
      .sample_i(sample_i),
      .i_o     (i_o),
      .q_o     (q_o),
      .valid_o (valid_o)
   );

   always #4 clk_i = ~clk_i;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model state
   longint pi [8];
   longint pq [8];
   int     cnt = 0;
   int     ph_next = 0;
   bit     ev [3];
   int     ei [3];
   int     eq [3];
   bit     ea [3];
   real    ai [3];
   real    aq [3];
   real    atol [3];
   bit     an_on = 1'b0;
   real    an_i, an_q, an_tol;

   function automatic int cosw(input int k);
      case (k % 8)
         0: return 255;
         1: return 180;
         3: return -180;
         4: return -255;
         5: return -180;
         7: return 180;
         default: return 0;
      endcase
   endfunction

   function automatic int sinw(input int k);
      return cosw((k + 6) % 8);
   endfunction

   function automatic int rnd(input longint s);
      return int'((s + 64'sd512) >>> 10);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input int x, input bit sy, input string tag);
      int  ph;
      longint si, sq;
      @(negedge clk_i);
      // outputs now reflect the sample driven three falling edges ago (R6)
      chk(valid_o == ev[2], {tag, " R7"}, "valid", longint'(valid_o), longint'(ev[2]));
      if (ev[2]) begin
         chk(i_o == ei[2], {tag, " R4 R5 R6"}, "I", i_o, ei[2]);
         chk(q_o == eq[2], {tag, " R4 R5 R6"}, "Q", q_o, eq[2]);
         if (ea[2]) begin
            chk(($itor(i_o) - ai[2]) <= atol[2] && (ai[2] - $itor(i_o)) <= atol[2],
                "R10", "sine I", i_o, longint'($rtoi(ai[2])));
            chk(($itor(q_o) - aq[2]) <= atol[2] && (aq[2] - $itor(q_o)) <= atol[2],
                "R10", "sine Q", q_o, longint'($rtoi(aq[2])));
         end
      end
      rst_i    = 1'b0;
      sample_i = 14'(x);
      sync_i   = sy;
      // model
      ph      = sy ? 0 : ph_next;
      ph_next = (ph + 1) % 8;
      if (sy) cnt = 0;
      for (int j = 7; j > 0; j--) begin
         pi[j] = pi[j-1];
         pq[j] = pq[j-1];
      end
      pi[0] = longint'(x) * cosw(ph);
      pq[0] = longint'(x) * sinw(ph);
      if (cnt < 8) cnt++;
      si = 0;
      sq = 0;
      for (int j = 0; j < cnt; j++) begin
         si += pi[j];
         sq += pq[j];
      end
      for (int j = 2; j > 0; j--) begin
         ev[j] = ev[j-1]; ei[j] = ei[j-1]; eq[j] = eq[j-1];
         ea[j] = ea[j-1]; ai[j] = ai[j-1]; aq[j] = aq[j-1]; atol[j] = atol[j-1];
      end
      ev[0] = (cnt == 8);
      ei[0] = rnd(si);
      eq[0] = rnd(sq);
      ea[0] = an_on;
      ai[0] = an_i;
      aq[0] = an_q;
      atol[0] = an_tol;
   endtask

   task automatic sine(input real amp, input real deg);
      real rad;
      rad    = deg * 3.14159265358979 / 180.0;
      an_on  = 1'b1;
      an_i   = amp * $cos(rad) * 1020.0 / 1024.0;
      an_q   = -amp * $sin(rad) * 1020.0 / 1024.0;
      an_tol = 2.0 + amp / 1000.0;
      for (int n = 0; n < 12; n++)
         step(int'(amp * $cos(2.0 * 3.14159265358979 * n / 8.0 + rad)), n == 0, "R10");
      an_on = 1'b0;
   endtask

   task automatic flush();
      for (int n = 0; n < 3; n++) step(0, 1'b0, "flush");
   endtask

   initial begin
      for (int j = 0; j < 8; j++) begin pi[j] = 0; pq[j] = 0; end
      for (int j = 0; j < 3; j++) begin
         ev[j] = 0; ei[j] = 0; eq[j] = 0; ea[j] = 0; ai[j] = 0.0; aq[j] = 0.0; atol[j] = 0.0;
      end
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk_i);
      // R1: quiet outputs while reset is held
      chk(i_o == 0, "R1", "I in reset", i_o, 0);
      chk(q_o == 0, "R1", "Q in reset", q_o, 0);
      chk(valid_o == 1'b0, "R1", "valid in reset", longint'(valid_o), 0);

      // R2/R3: impulse walking through every slot after a sync
      for (int k = 0; k < 8; k++)
         for (int j = 0; j < 8; j++)
            step((j == k) ? 1000 : -0, j == 0, "R2 R3");
      // R4: an impulse leaves the window after eight newer samples
      step(1000, 1'b1, "R4");
      for (int j = 0; j < 11; j++) step(0, 1'b0, "R4");
      // R2: slot counter wraps without sync
      for (int j = 0; j < 20; j++) step((j % 5 == 0) ? 777 : -33, 1'b0, "R2");

      // R9: full-scale patterns
      for (int n = 0; n < 16; n++) step(cosw(n) >= 0 ? 8191 : -8192, n == 0, "R9");
      for (int n = 0; n < 16; n++) step(sinw(n) >= 0 ? -8192 : 8191, 1'b0, "R9");
      for (int n = 0; n < 12; n++) step(8191, 1'b0, "R9");
      for (int n = 0; n < 12; n++) step(-8192, 1'b0, "R9");

      // R10: sinusoids of known amplitude and phase
      sine(8000.0, 0.0);
      sine(8000.0, 135.0);
      sine(3000.0, 30.0);
      sine(3000.0, 200.0);
      sine(500.0, 90.0);
      sine(500.0, 300.0);
      flush();

      // R8: sync in mid-window and back to back
      for (int n = 0; n < 30; n++)
         step(int'($urandom_range(16383)) - 8192,
              n == 0 || n == 3 || n == 4 || n == 12 || n == 19, "R8");

      // R4 R5 R7: random stream with occasional syncs
      for (int n = 0; n < 3000; n++)
         step(int'($urandom_range(16383)) - 8192, $urandom_range(63) == 0, "rand");
      flush();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule